// File: doc/BRIEF.md
# DMA Transfer Counter with Length Clamp

This block holds the 24-bit transfer count for the DMA path of a SCSI bus controller. Software loads the count one byte at a time into a shadow copy. Every command strobe that carries the DMA flag copies the shadow into the live counter. A command without the flag switches the block to programmed-I/O mode and leaves the live counter alone.

A transfer command with the DMA flag set starts a transfer. The block takes the programmed count, with zero standing for 65536, and clamps it against a limit. In command phase the limit is 32 bytes. Otherwise the limit is the magnitude of the signed remaining-size input, whose sign gives the direction. The clamped length is presented on `xfer_len`. As bytes are acknowledged, the live counter and the outstanding length count down and the tracked remaining size steps toward zero. When the last byte is acknowledged, the block sets terminal count, zeroes the live counter, latches a bus-service interrupt cause, raises the interrupt and pulses `done`.

Top module: `dxc_top`

## Requirements
- R1: A count-byte write with `cnt_wr_sel` 0, 1 or 2 stores `cnt_wr_data` into bits 7:0, 15:8 or 23:16 of the shadow count. A write with select 3 stores nothing.
- R2: A command strobe with `cmd_dma`=1 copies the shadow count into `live_count` and sets `dma_mode` to 1. A strobe with `cmd_dma`=0 clears `dma_mode` and leaves `live_count` unchanged.
- R3: When a transfer starts while the shadow count is zero, the count is taken as 65536. Both `live_count` and the unclamped length use that value.
- R4: When a transfer starts outside command phase, `xfer_len` is the smaller of the effective count and the magnitude of `rem_size`. `dir_to_dev` is 1 exactly when `rem_size` is negative.
- R5: When a transfer starts in command phase (`cmd_phase`=1), `xfer_len` is the smaller of the effective count and 32. Acknowledged bytes then leave `rem_now` unchanged.
- R6: Starting a transfer of non-zero length clears `term_count`, and so does any count-byte write. If a completion falls in the same cycle as a write, `term_count` is set, and the written byte is still stored.
- R7: In the cycle after the last byte is acknowledged, or after a transfer starts with length zero, the outputs show `term_count`=1, `live_count`=0, `irq`=1, `int_cause`=8'h10 (bus service) and `done`=1.
- R8: Each accepted byte acknowledge decrements `live_count` by one. Outside command phase it also moves `rem_now` one step toward zero: +1 when the direction is host to device, -1 when it is device to host. An acknowledge is ignored when no bytes are outstanding or when it coincides with a command strobe.
- R9: `done` is high for one cycle per completion.
- R10: A command strobe that does not itself complete a transfer clears `irq` and sets `int_cause` to 0.
- R11: A transfer command without the DMA flag leaves `xfer_len` and `live_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr_en | input | 1 | Count-byte write strobe |
| cnt_wr_sel | input | 2 | Byte select: 0 low, 1 middle, 2 high, 3 none |
| cnt_wr_data | input | 8 | Count byte to write |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| cmd_xfer | input | 1 | Command is a transfer command |
| cmd_phase | input | 1 | Bus is in command phase |
| rem_size | input | 18 | Signed remaining size; negative means host to device |
| byte_ack | input | 1 | One byte moved |
| xfer_len | output | 18 | Clamped length of the current transfer |
| live_count | output | 24 | Live transfer counter |
| rem_now | output | 18 | Tracked signed remaining size |
| dir_to_dev | output | 1 | Current transfer is host to device |
| dma_mode | output | 1 | Last command carried the DMA flag |
| xfer_active | output | 1 | Bytes still outstanding |
| term_count | output | 1 | Terminal count status |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt request |
| int_cause | output | 8 | Interrupt cause; 8'h10 is bus service |

## Verification
Two pairs of events can land on the same clock edge. In the first, the final byte acknowledge arrives in the same cycle as a count-byte write. That write would clear terminal count while the completion sets it. The bench drives both in one cycle and expects `term_count` and `done` high. It then reloads the live counter to confirm that the byte was stored. In the second, a byte acknowledge coincides with a command strobe. The bench expects the acknowledge to be dropped, which leaves `live_count` unchanged.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  localparam logic [7:0] CAUSE_NONE    = 8'h00;
  localparam logic [7:0] CAUSE_BUS_SVC = 8'h10;
endpackage

// File: rtl/dxc_count_regs.sv
module dxc_count_regs #(
  parameter int CNT_W = 24,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             reload,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             clear,
  output logic [CNT_W-1:0] shadow,
  output logic [CNT_W-1:0] live
);
  localparam int NBYTES = CNT_W / 8;

  // shadow bytes, one lane per written byte
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] byte_q, byte_n;
    logic       lane_we;
    assign lane_we = wr_en && (wr_sel == SEL_W'(b));
    always_comb begin
      byte_n = byte_q;
      if (lane_we) byte_n = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= 8'h00;
      else        byte_q <= byte_n;
    end
    assign shadow[b*8 +: 8] = byte_q;
  end

  logic [CNT_W-1:0] live_q, live_n;

  always_comb begin
    live_n = live_q;
    if (clear)                           live_n = '0;
    else if (load)                       live_n = load_val;
    else if (reload)                     live_n = shadow;
    else if (dec && (live_q != '0))      live_n = live_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_n;
  end

  assign live = live_q;

  AST_RELOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !load && !clear) |=> (live == $past(shadow))); // R2
endmodule

// File: rtl/dxc_len_clamp.sv
module dxc_len_clamp #(
  parameter int CNT_W    = 24,
  parameter int RS_W     = 18,
  parameter int LEN_W    = 18,
  parameter int ZERO_CNT = 65536,
  parameter int CMD_MAX  = 32
) (
  input  logic                    phase,
  input  logic [CNT_W-1:0]        cnt,
  input  logic signed [RS_W-1:0]  rem,
  output logic [CNT_W-1:0]        eff,
  output logic [LEN_W-1:0]        len
);
  logic [RS_W-1:0]  mag;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] len_full;

  always_comb begin
    eff      = (cnt == '0) ? CNT_W'(ZERO_CNT) : cnt;
    mag      = rem[RS_W-1] ? RS_W'(-rem) : RS_W'(rem);
    limit    = phase ? CNT_W'(CMD_MAX) : CNT_W'(mag);
    len_full = (eff < limit) ? eff : limit;
    len      = len_full[LEN_W-1:0];
  end

  always_comb begin
    AST_CMD_CAP: assert (!phase || (len <= LEN_W'(CMD_MAX))); // R5
  end
endmodule

// File: rtl/dxc_xfer_seq.sv
module dxc_xfer_seq
  import dxc_pkg::*;
#(
  parameter int RS_W  = 18,
  parameter int LEN_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LEN_W-1:0]       start_len,
  input  logic                   start_phase,
  input  logic signed [RS_W-1:0] start_rem,
  input  logic                   cmd_valid,
  input  logic                   ack,
  input  logic                   wr_en,
  output logic                   acc,
  output logic                   fin,
  output logic [LEN_W-1:0]       xfer_len,
  output logic signed [RS_W-1:0] rem_now,
  output logic                   dir_to_dev,
  output logic                   active,
  output logic                   term_count,
  output logic                   done,
  output logic                   irq,
  output logic [7:0]             int_cause
);
  localparam logic signed [RS_W-1:0] ONE_S = RS_W'(1);

  logic [LEN_W-1:0]       len_q, len_n, left_q, left_n;
  logic signed [RS_W-1:0] rem_q, rem_n;
  logic                   phase_q, phase_n, dir_q, dir_n;
  logic                   tc_q, tc_n, done_q, irq_q, irq_n;
  logic [7:0]             cause_q, cause_n;

  // accepted acknowledge and completion event
  assign acc = ack && !cmd_valid && (left_q != '0);
  assign fin = (start && (start_len == '0)) || (acc && (left_q == LEN_W'(1)));

  always_comb begin
    len_n   = len_q;
    left_n  = left_q;
    rem_n   = rem_q;
    phase_n = phase_q;
    dir_n   = dir_q;
    if (start) begin
      len_n   = start_len;
      left_n  = start_len;
      rem_n   = start_rem;
      phase_n = start_phase;
      dir_n   = start_rem[RS_W-1];
    end else if (acc) begin
      left_n = left_q - LEN_W'(1);
      if (!phase_q) rem_n = dir_q ? (rem_q + ONE_S) : (rem_q - ONE_S);
    end
  end

  always_comb begin
    tc_n    = tc_q;
    irq_n   = irq_q;
    cause_n = cause_q;
    if (fin)                  tc_n = 1'b1;
    else if (start || wr_en)  tc_n = 1'b0;
    if (fin) begin
      irq_n   = 1'b1;
      cause_n = CAUSE_BUS_SVC;
    end else if (cmd_valid) begin
      irq_n   = 1'b0;
      cause_n = CAUSE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      left_q  <= '0;
      rem_q   <= '0;
      phase_q <= 1'b0;
      dir_q   <= 1'b0;
      tc_q    <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      len_q   <= len_n;
      left_q  <= left_n;
      rem_q   <= rem_n;
      phase_q <= phase_n;
      dir_q   <= dir_n;
      tc_q    <= tc_n;
      done_q  <= fin;
      irq_q   <= irq_n;
      cause_q <= cause_n;
    end
  end

  assign xfer_len   = len_q;
  assign rem_now    = rem_q;
  assign dir_to_dev = dir_q;
  assign active     = (left_q != '0);
  assign term_count = tc_q;
  assign done       = done_q;
  assign irq        = irq_q;
  assign int_cause  = cause_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R9
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_q == '0) && !start) |=> ($stable(rem_q) && (left_q == '0))); // R8
  AST_START_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (start_len != '0)) |=> !term_count); // R6
endmodule

// File: rtl/dxc_top.sv
module dxc_top
  import dxc_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int RS_W     = 18,
  parameter int SEL_W    = 2,
  parameter int ZERO_CNT = 65536,
  parameter int CMD_MAX  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_wr_en,
  input  logic [SEL_W-1:0]       cnt_wr_sel,
  input  logic [7:0]             cnt_wr_data,
  input  logic                   cmd_valid,
  input  logic                   cmd_dma,
  input  logic                   cmd_xfer,
  input  logic                   cmd_phase,
  input  logic signed [RS_W-1:0] rem_size,
  input  logic                   byte_ack,
  output logic [RS_W-1:0]        xfer_len,
  output logic [CNT_W-1:0]       live_count,
  output logic signed [RS_W-1:0] rem_now,
  output logic                   dir_to_dev,
  output logic                   dma_mode,
  output logic                   xfer_active,
  output logic                   term_count,
  output logic                   done,
  output logic                   irq,
  output logic [7:0]             int_cause
);
  localparam int LEN_W = RS_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             start, reload, acc, fin;
  logic [CNT_W-1:0] shadow, eff;
  logic [LEN_W-1:0] len_c;
  logic             dma_q, dma_n;

  assign reload = cmd_valid && cmd_dma;
  assign start  = reload && cmd_xfer;

  always_comb begin
    dma_n = dma_q;
    if (cmd_valid) dma_n = cmd_dma;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) dma_q <= 1'b0;
    else            dma_q <= dma_n;
  end
  assign dma_mode = dma_q;

  dxc_count_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (cnt_wr_en),
    .wr_sel   (cnt_wr_sel),
    .wr_data  (cnt_wr_data),
    .reload   (reload),
    .load     (start),
    .load_val (eff),
    .dec      (acc),
    .clear    (fin),
    .shadow   (shadow),
    .live     (live_count)
  );

  dxc_len_clamp #(
    .CNT_W(CNT_W), .RS_W(RS_W), .LEN_W(LEN_W),
    .ZERO_CNT(ZERO_CNT), .CMD_MAX(CMD_MAX)
  ) u_clamp (
    .phase (cmd_phase),
    .cnt   (shadow),
    .rem   (rem_size),
    .eff   (eff),
    .len   (len_c)
  );

  dxc_xfer_seq #(.RS_W(RS_W), .LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .start_len   (len_c),
    .start_phase (cmd_phase),
    .start_rem   (rem_size),
    .cmd_valid   (cmd_valid),
    .ack         (byte_ack),
    .wr_en       (cnt_wr_en),
    .acc         (acc),
    .fin         (fin),
    .xfer_len    (xfer_len),
    .rem_now     (rem_now),
    .dir_to_dev  (dir_to_dev),
    .active      (xfer_active),
    .term_count  (term_count),
    .done        (done),
    .irq         (irq),
    .int_cause   (int_cause)
  );

  AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (term_count && (live_count == '0) && irq && (int_cause == CAUSE_BUS_SVC))); // R7
endmodule

// File: tb/dxc_top_tb.sv
`timescale 1ns/1ps
module dxc_top_tb;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cnt_wr_en = 1'b0;
  logic [1:0]         cnt_wr_sel = 2'd0;
  logic [7:0]         cnt_wr_data = 8'h00;
  logic               cmd_valid = 1'b0, cmd_dma = 1'b0, cmd_xfer = 1'b0, cmd_phase = 1'b0;
  logic signed [17:0] rem_size = '0;
  logic               byte_ack = 1'b0;
  logic [17:0]        xfer_len;
  logic [23:0]        live_count;
  logic signed [17:0] rem_now;
  logic               dir_to_dev, dma_mode, xfer_active, term_count, done, irq;
  logic [7:0]         int_cause;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dxc_top u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel),
    .cnt_wr_data(cnt_wr_data), .cmd_valid(cmd_valid), .cmd_dma(cmd_dma),
    .cmd_xfer(cmd_xfer), .cmd_phase(cmd_phase), .rem_size(rem_size),
    .byte_ack(byte_ack), .xfer_len(xfer_len), .live_count(live_count),
    .rem_now(rem_now), .dir_to_dev(dir_to_dev), .dma_mode(dma_mode),
    .xfer_active(xfer_active), .term_count(term_count), .done(done),
    .irq(irq), .int_cause(int_cause)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // every step: drive at a falling edge, one rising edge, release
  task automatic step();
    @(negedge clk);
    cnt_wr_en = 1'b0; cmd_valid = 1'b0; byte_ack = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cnt_wr_en = 1'b1; cnt_wr_sel = sel; cnt_wr_data = d; step();
  endtask

  task automatic load_count(input int v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]); wr(2'd2, v[23:16]);
  endtask

  task automatic cmd(input bit dma, input bit xf, input bit ph);
    cmd_valid = 1'b1; cmd_dma = dma; cmd_xfer = xf; cmd_phase = ph; step();
  endtask

  task automatic ack();
    byte_ack = 1'b1; step();
  endtask

  task automatic t_reset();
    chk_eq("R7 reset term_count", int'(term_count), 0);
    chk_eq("R9 reset done", int'(done), 0);
    chk_eq("R10 reset irq", int'(irq), 0);
    chk_eq("R2 reset live_count", int'(live_count), 0);
    chk_eq("R2 reset dma_mode", int'(dma_mode), 0);
    chk_eq("R4 reset xfer_len", int'(xfer_len), 0);
  endtask

  task automatic t_assemble();
    load_count(32'h001234);
    cmd(1'b1, 1'b0, 1'b0);
    chk_eq("R1 assembled count", int'(live_count), 32'h001234);
    chk_eq("R2 dma_mode set", int'(dma_mode), 1);
    wr(2'd2, 8'h56);
    cmd(1'b0, 1'b0, 1'b0);
    chk_eq("R2 no-flag keeps live", int'(live_count), 32'h001234);
    chk_eq("R2 dma_mode cleared", int'(dma_mode), 0);
    wr(2'd3, 8'hFF);
    cmd(1'b1, 1'b0, 1'b0);
    chk_eq("R1 high byte and sel3 ignored", int'(live_count), 32'h561234);
  endtask

  task automatic t_forward();
    load_count(5);
    rem_size = 18'sd8;
    cmd(1'b1, 1'b1, 1'b0);
    chk_eq("R4 clamp to count", int'(xfer_len), 5);
    chk_eq("R4 dir device-to-host", int'(dir_to_dev), 0);
    chk_eq("R4 rem_now loaded", int'(rem_now), 8);
    ack(); ack();
    chk_eq("R8 live after 2 acks", int'(live_count), 3);
    chk_eq("R8 rem_now after 2 acks", int'(rem_now), 6);
    ack(); ack();
    chk_eq("R9 no done before last", int'(done), 0);
    ack();
    chk_eq("R7 done", int'(done), 1);
    chk_eq("R7 term_count", int'(term_count), 1);
    chk_eq("R7 live zeroed", int'(live_count), 0);
    chk_eq("R7 irq", int'(irq), 1);
    chk_eq("R7 cause bus service", int'(int_cause), 8'h10);
    chk_eq("R8 rem_now final", int'(rem_now), 3);
    step();
    chk_eq("R9 done one cycle", int'(done), 0);
    ack();
    chk_eq("R8 late ack rem_now", int'(rem_now), 3);
    chk_eq("R8 late ack done", int'(done), 0);
    chk_eq("R8 late ack active", int'(xfer_active), 0);
  endtask

  task automatic t_irq_clear();
    cmd(1'b0, 1'b0, 1'b0);
    chk_eq("R10 irq cleared", int'(irq), 0);
    chk_eq("R10 cause cleared", int'(int_cause), 0);
    chk_eq("R6 tc kept by plain cmd", int'(term_count), 1);
    wr(2'd0, 8'h00);
    chk_eq("R6 write clears tc", int'(term_count), 0);
  endtask

  task automatic t_reverse();
    load_count(256);
    rem_size = -18'sd3;
    cmd(1'b1, 1'b1, 1'b0);
    chk_eq("R4 clamp to |rem|", int'(xfer_len), 3);
    chk_eq("R4 dir host-to-device", int'(dir_to_dev), 1);
    ack();
    chk_eq("R8 rem_now toward zero", int'(rem_now), -2);
    chk_eq("R8 live dec", int'(live_count), 255);
  endtask

  task automatic t_zero_count();
    load_count(0);
    rem_size = 18'sd70000;
    cmd(1'b1, 1'b1, 1'b0);
    chk_eq("R3 zero means 65536 len", int'(xfer_len), 65536);
    chk_eq("R3 zero means 65536 live", int'(live_count), 65536);
  endtask

  task automatic t_cmd_phase();
    load_count(100);
    rem_size = 18'sd50;
    cmd(1'b1, 1'b1, 1'b1);
    chk_eq("R5 cap 32", int'(xfer_len), 32);
    ack();
    chk_eq("R5 rem_now untouched", int'(rem_now), 50);
    chk_eq("R8 live dec in cmd phase", int'(live_count), 99);
  endtask

  task automatic t_pio_and_collision();
    rem_size = 18'sd7;
    cmd(1'b0, 1'b1, 1'b0);
    chk_eq("R11 pio len unchanged", int'(xfer_len), 32);
    chk_eq("R11 pio live unchanged", int'(live_count), 99);
    chk_eq("R11 dma_mode off", int'(dma_mode), 0);
    byte_ack = 1'b1;
    cmd(1'b0, 1'b0, 1'b0);
    chk_eq("R8 ack with cmd ignored", int'(live_count), 99);
  endtask

  task automatic t_zero_len_and_overlap();
    load_count(5);
    rem_size = 18'sd0;
    cmd(1'b1, 1'b1, 1'b0);
    chk_eq("R7 zero-len done", int'(done), 1);
    chk_eq("R7 zero-len tc", int'(term_count), 1);
    chk_eq("R7 zero-len live", int'(live_count), 0);
    rem_size = 18'sd2;
    cmd(1'b1, 1'b1, 1'b0);
    chk_eq("R6 start clears tc", int'(term_count), 0);
    chk_eq("R4 len 2", int'(xfer_len), 2);
    ack();
    byte_ack = 1'b1;
    wr(2'd0, 8'h09);
    chk_eq("R6 completion beats write", int'(term_count), 1);
    chk_eq("R7 done on overlap", int'(done), 1);
    cmd(1'b1, 1'b0, 1'b0);
    chk_eq("R6 overlapped write stored", int'(live_count), 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_assemble();
    t_forward();
    t_irq_clear();
    t_reverse();
    t_zero_count();
    t_cmd_phase();
    t_pio_and_collision();
    t_zero_len_and_overlap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule